// File: doc/BRIEF.md
# Programmable Offset Pulse-Per-Second Generator

This block runs from one fast oscillator clock and produces two pulse trains. The first is a reference train at one of four selectable rates: 1, 10, 100 or 1000 pulses per second. The second is an offset train at the same rate. Its phase can be placed anywhere in the reference period, with one clock period as the coarse step. At the default 200 MHz clock that step is 5 ns, and the reach exceeds one second. The block also drives a fine-delay word to an external analog interpolator, which places the edge between the 5 ns steps.

A host processor shifts a settings frame in over a three-wire serial port and then raises a load strobe. The block holds the captured frame as pending. It moves the frame into the live registers together, at the next reference epoch, so that no period is cut short and no pulse is torn. Every output pulse lasts a fixed number of clocks: 4000 at 200 MHz, which is 20 µs.

Top module: `ppsgen_top`

## Requirements
- R1: The reference period in clocks is BASE_CYC divided by 1, 10, 100 or 1000, chosen by the rate field: 00, 01, 10 or 11 respectively. Consecutive reference rising edges are exactly that many clocks apart.
- R2: Every pulse on `refPps` and on `ofsPps` stays high for exactly PULSE_CYC clocks.
- R3: The `ofsPps` rising edge follows the `refPps` rising edge of the same period by (coarse offset mod period) clocks. An offset of zero makes the two edges coincide.
- R4: The port captures `sdata` on each rising edge of `sclk`, most significant bit first. A rising edge of `sload` takes the last 40 bits as a frame. From the top down, the frame holds a 2-bit rate field, then the 28-bit coarse offset, then the 10-bit fine code in the lowest bits.
- R5: A loaded frame takes effect only at a reference epoch. Every interval between reference rising edges therefore equals one full period of some valid rate, even when the rate changes.
- R6: `fineCode` takes the fine field of the latest applied frame. It changes only at an edge after which both `refPps` and `ofsPps` are low.
- R7: Synchronous reset clears both outputs and the phase counter. It sets the rate to 1 pps, the coarse offset to zero and the fine code to zero.
- R8: An offset pulse that starts near the end of a period runs on into the next period and still keeps its full width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock; one period is the coarse step |
| rst | input | 1 | Synchronous active-high reset |
| sclk | input | 1 | Serial shift clock from the host, sampled by clk |
| sdata | input | 1 | Serial data, MSB first |
| sload | input | 1 | Rising edge latches the shifted frame as pending |
| refPps | output | 1 | Reference pulse train |
| ofsPps | output | 1 | Offset pulse train |
| fineCode | output | FINE_W | Sub-step delay word for the external interpolator |

## Verification
The bench targets the offset extremes. It uses zero, where a one-cycle latency mismatch would separate the two edges. It uses period minus one, where a design that stopped the pulse at the wrap would emit a short pulse. It uses values far above the period, which a design without the modulo reduction would never match, so the offset pulse would be lost. Rate changes are loaded mid-period: a design that applied the frame at once would show one truncated reference interval. It also watches every fine-code change, which a design that updated the code at load time would make while a pulse was high.

// File: rtl/ppsgen_pkg.sv
package ppsgen_pkg;

  typedef enum logic [1:0] {
    RATE_1   = 2'b00,
    RATE_10  = 2'b01,
    RATE_100 = 2'b10,
    RATE_1K  = 2'b11
  } rate_e;

  // strobes from datapath to control
  typedef struct packed {
    logic epoch;    // last cycle of a reference period
    logic refNext;  // value refPps takes at the next edge
    logic offNext;  // value ofsPps takes at the next edge
  } dpStrobe_t;

  function automatic int unsigned periodOf(int unsigned base, rate_e r);
    case (r)
      RATE_1:   return base;
      RATE_10:  return base / 10;
      RATE_100: return base / 100;
      default:  return base / 1000;
    endcase
  endfunction

endpackage

// File: rtl/ppsgen_ctrl.sv
module ppsgen_ctrl
  import ppsgen_pkg::*;
#(
  parameter int unsigned BASE_CYC = 200_000_000,
  parameter int unsigned OFS_W    = 28,
  parameter int unsigned FINE_W   = 10,
  parameter int unsigned PH_W     = 28
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sclk,
  input  logic              sdata,
  input  logic              sload,
  input  dpStrobe_t         dpSt,
  output rate_e             rate,
  output logic [PH_W-1:0]   coarse,
  output logic [FINE_W-1:0] fine
);
  localparam int unsigned FRAME_W = 2 + OFS_W + FINE_W;
  localparam int unsigned CW      = (OFS_W > PH_W) ? OFS_W : PH_W;

  logic [2:0]         sclkSync, loadSync;
  logic [1:0]         dataSync;
  logic [FRAME_W-1:0] shreg;
  rate_e              pendRate;
  logic [OFS_W-1:0]   pendCoarse;
  logic [FINE_W-1:0]  pendFine, fineHold;
  logic               pendValid, finePend;
  logic               shiftEn, loadEn, apply, quiet;

  function automatic logic [PH_W-1:0] reduceOfs(logic [OFS_W-1:0] v, rate_e r);
    logic [CW-1:0] ext, per;
    ext = CW'(v);
    per = CW'(periodOf(BASE_CYC, r));
    return PH_W'(ext % per);
  endfunction

  assign shiftEn = sclkSync[1] & ~sclkSync[2];
  assign loadEn  = loadSync[1] & ~loadSync[2];
  assign apply   = dpSt.epoch & pendValid;
  assign quiet   = ~dpSt.refNext & ~dpSt.offNext;

  // host port sampling and shifting
  always_ff @(posedge clk) begin
    if (rst) begin
      sclkSync <= '0;
      loadSync <= '0;
      dataSync <= '0;
      shreg    <= '0;
    end else begin
      sclkSync <= {sclkSync[1:0], sclk};
      loadSync <= {loadSync[1:0], sload};
      dataSync <= {dataSync[0], sdata};
      if (shiftEn) shreg <= {shreg[FRAME_W-2:0], dataSync[1]};
    end
  end

  // pending frame, applied on the epoch
  always_ff @(posedge clk) begin
    if (rst) begin
      pendRate   <= RATE_1;
      pendCoarse <= '0;
      pendFine   <= '0;
      pendValid  <= 1'b0;
      rate       <= RATE_1;
      coarse     <= '0;
      fineHold   <= '0;
      finePend   <= 1'b0;
      fine       <= '0;
    end else begin
      if (loadEn) begin
        pendRate   <= rate_e'(shreg[FRAME_W-1 -: 2]);
        pendCoarse <= shreg[FINE_W +: OFS_W];
        pendFine   <= shreg[FINE_W-1:0];
        pendValid  <= 1'b1;
      end else if (dpSt.epoch) begin
        pendValid  <= 1'b0;
      end

      if (apply) begin
        rate     <= pendRate;
        coarse   <= reduceOfs(pendCoarse, pendRate);
        fineHold <= pendFine;
        finePend <= 1'b1;
      end else if (finePend && quiet) begin
        fine     <= fineHold;
        finePend <= 1'b0;
      end
    end
  end

  // R5: live rate moves only on a reference epoch
  a_r5_rate_on_epoch: assert property (@(posedge clk) disable iff (rst)
    !$stable(rate) |-> $past(dpSt.epoch));

  // R3: live coarse offset is always inside the live period
  a_r3_coarse_in_period: assert property (@(posedge clk) disable iff (rst)
    CW'(coarse) < CW'(periodOf(BASE_CYC, rate)));

endmodule

// File: rtl/ppsgen_dp.sv
module ppsgen_dp
  import ppsgen_pkg::*;
#(
  parameter int unsigned BASE_CYC  = 200_000_000,
  parameter int unsigned PH_W      = 28,
  parameter int unsigned PULSE_CYC = 4000
) (
  input  logic            clk,
  input  logic            rst,
  input  rate_e           rate,
  input  logic [PH_W-1:0] coarse,
  output dpStrobe_t       dpSt,
  output logic            refOut,
  output logic            offOut
);
  localparam int unsigned PW_W = $clog2(PULSE_CYC + 1);

  logic [PH_W-1:0] phase, period;
  logic            lastHit, offStart, refNext, offNext;
  logic [PW_W-1:0] offCnt;

  assign period   = PH_W'(periodOf(BASE_CYC, rate));
  assign offStart = (phase == coarse);
  assign offNext  = offStart | (offCnt != '0);
  assign refNext  = (phase < PH_W'(PULSE_CYC));

  assign dpSt.epoch   = lastHit;
  assign dpSt.refNext = refNext;
  assign dpSt.offNext = offNext;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase   <= '0;
      lastHit <= 1'b0;
      offCnt  <= '0;
      refOut  <= 1'b0;
      offOut  <= 1'b0;
    end else begin
      // terminal compare is registered, so it looks one count ahead
      lastHit <= (phase == period - PH_W'(2));
      phase   <= lastHit ? '0 : phase + PH_W'(1);
      if (offStart)          offCnt <= PW_W'(PULSE_CYC - 1);
      else if (offCnt != '0) offCnt <= offCnt - PW_W'(1);
      refOut  <= refNext;
      offOut  <= offNext;
    end
  end

  a_r1_phase_bound: assert property (@(posedge clk) disable iff (rst)
    phase < period);

  a_r1_hit_at_end: assert property (@(posedge clk) disable iff (rst)
    lastHit |-> (phase == period - PH_W'(1)));

  a_r2_width_bound: assert property (@(posedge clk) disable iff (rst)
    offCnt < PW_W'(PULSE_CYC));

  a_r7_reset_clear: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!refOut && !offOut && phase == '0));

endmodule

// File: rtl/ppsgen_top.sv
module ppsgen_top
  import ppsgen_pkg::*;
#(
  parameter int unsigned BASE_CYC  = 200_000_000,
  parameter int unsigned OFS_W     = 28,
  parameter int unsigned FINE_W    = 10,
  parameter int unsigned PULSE_CYC = 4000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sclk,
  input  logic              sdata,
  input  logic              sload,
  output logic              refPps,
  output logic              ofsPps,
  output logic [FINE_W-1:0] fineCode
);
  localparam int unsigned PH_W = $clog2(BASE_CYC);

  rate_e           rate;
  logic [PH_W-1:0] coarse;
  dpStrobe_t       dpSt;

  ppsgen_ctrl #(
    .BASE_CYC(BASE_CYC), .OFS_W(OFS_W), .FINE_W(FINE_W), .PH_W(PH_W)
  ) uCtrl (
    .clk(clk), .rst(rst), .sclk(sclk), .sdata(sdata), .sload(sload),
    .dpSt(dpSt), .rate(rate), .coarse(coarse), .fine(fineCode)
  );

  ppsgen_dp #(
    .BASE_CYC(BASE_CYC), .PH_W(PH_W), .PULSE_CYC(PULSE_CYC)
  ) uDp (
    .clk(clk), .rst(rst), .rate(rate), .coarse(coarse),
    .dpSt(dpSt), .refOut(refPps), .offOut(ofsPps)
  );

  // R6: interpolator word never moves under a high pulse
  a_r6_fine_quiet: assert property (@(posedge clk) disable iff (rst)
    !$stable(fineCode) |-> (!refPps && !ofsPps));

endmodule

// File: tb/sim_ppsgen_top.sv
`timescale 1ns/100ps
module sim_ppsgen_top;
  localparam int unsigned BASE   = 20000;
  localparam int unsigned OFS_W  = 28;
  localparam int unsigned FINE_W = 10;
  localparam int unsigned PW     = 8;

  logic clk = 1'b0, rst = 1'b1, sclk = 1'b0, sdata = 1'b0, sload = 1'b0;
  logic refPps, ofsPps;
  logic [FINE_W-1:0] fineCode;

  always #2.5 clk = ~clk;

  ppsgen_top #(.BASE_CYC(BASE), .OFS_W(OFS_W), .FINE_W(FINE_W), .PULSE_CYC(PW)) u0 (
    .clk(clk), .rst(rst), .sclk(sclk), .sdata(sdata), .sload(sload),
    .refPps(refPps), .ofsPps(ofsPps), .fineCode(fineCode)
  );

  int nChecks = 0, nFail = 0;
  longint cyc = 0, refRiseCyc = 0, ofsRiseCyc = 0;
  longint lastInterval = 0, lastRefW = 0, lastOfsW = 0, lastDelay = -1;
  int refRises = 0, ofsRises = 0, ofsFalls = 0, badInterval = 0, fineBad = 0;
  bit haveRef = 0, refPrev = 0, ofsPrev = 0;
  logic [FINE_W-1:0] finePrev = '0;

  function automatic longint expPeriod(int r);
    case (r)
      0: return BASE;
      1: return BASE / 10;
      2: return BASE / 100;
      default: return BASE / 1000;
    endcase
  endfunction

  task automatic chk(string tag, longint act, longint exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // edge monitor, sampled mid-cycle
  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      if (refPps && !refPrev) begin
        if (haveRef) begin
          lastInterval = cyc - refRiseCyc;
          if (lastInterval != BASE && lastInterval != BASE/10 &&
              lastInterval != BASE/100 && lastInterval != BASE/1000) badInterval++;
        end
        refRiseCyc = cyc; haveRef = 1; refRises++;
      end
      if (!refPps && refPrev) lastRefW = cyc - refRiseCyc;
      if (ofsPps && !ofsPrev) begin
        ofsRiseCyc = cyc; lastDelay = cyc - refRiseCyc; ofsRises++;
      end
      if (!ofsPps && ofsPrev) begin
        lastOfsW = cyc - ofsRiseCyc; ofsFalls++;
      end
      if (fineCode != finePrev && (refPps || ofsPps)) fineBad++;
    end
    refPrev = refPps; ofsPrev = ofsPps; finePrev = fineCode;
  end

  task automatic ticks(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic sendFrame(logic [1:0] r, logic [OFS_W-1:0] c, logic [FINE_W-1:0] f);
    logic [2+OFS_W+FINE_W-1:0] frame;
    frame = {r, c, f};
    for (int i = 2 + OFS_W + FINE_W - 1; i >= 0; i--) begin
      sdata = frame[i]; ticks(3);
      sclk = 1'b1;      ticks(3);
      sclk = 1'b0;
    end
    ticks(3);
    sload = 1'b1; ticks(3);
    sload = 1'b0; ticks(3);
  endtask

  // R4 frame, then R1 R2 R3 R6 after the frame has settled
  task automatic runCase(int r, longint c, int f, string name);
    int target;
    longint p;
    p = expPeriod(r);
    sendFrame(r[1:0], c[OFS_W-1:0], f[FINE_W-1:0]);
    target = refRises + 3;
    while (refRises < target) ticks(1);
    target = ofsRises + 1;
    while (ofsRises < target) ticks(1);
    chk({"R1 period ", name}, lastInterval, p);
    chk({"R3 offset delay ", name}, lastDelay, c % p);
    target = ofsFalls + 1;
    while (ofsFalls < target) ticks(1);
    ticks(PW + 2);
    chk({"R2 ref width ", name}, lastRefW, PW);
    chk({"R2 ofs width ", name}, lastOfsW, PW);
    chk({"R4 R6 fine code ", name}, fineCode, f);
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    nChecks++; nFail++;
    $display("FAIL watchdog expired actual=%0d expected=done", cyc);
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'h5EED_0042);
    ticks(4);
    chk("R7 ref low in reset", refPps, 0);
    chk("R7 ofs low in reset", ofsPps, 0);
    rst = 1'b0;
    ticks(PW + 4);
    chk("R7 fine zero after reset", fineCode, 0);
    chk("R7 default offset zero", lastDelay, 0);
    chk("R7 default ref width", lastRefW, PW);

    runCase(0, 12345, 10'h2A5, "1pps");
    runCase(2, 0, 10'h3FF, "zero offset");
    runCase(3, 19, 10'h001, "R8 wrap");
    runCase(1, 28'hFFFFFFF, 10'h155, "max coarse");
    runCase(3, 40, 10'h0F0, "offset above period");
    for (int k = 0; k < 7; k++) begin
      int r;
      longint c;
      r = 1 + int'($urandom % 3);
      c = longint'($urandom % 28'hFFFFFFF);
      if (k % 2 == 0) c = c % expPeriod(r);
      runCase(r, c, int'($urandom % 1024), "random");
    end

    chk("R5 no torn reference interval", badInterval, 0);
    chk("R6 fine changed under pulse", fineBad, 0);
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule